// File: doc/BRIEF.md
# Audio Capture Ring Buffer Controller

The block takes audio sample words from a receiver, one per strobe, and stores them as 16-bit words in an on-chip ring buffer. A host empties the buffer through a 16-bit register bus. While recording is enabled, each accepted sample is trimmed to the selected sample width (right-justified) and written at the write pointer. Reading the data port returns the word at the read pointer and advances that pointer. Both pointers can be read back as word addresses.

Two kinds of alarm are raised. A buffer-level alarm holds while the fill is at or above a chosen fraction of the buffer. A sticky overrun alarm is set when a sample does not fit. A third interrupt source, from the external receiver, is passed through as status. A single `irq` line is the OR of the enabled sources. For bring-up, a test mode replaces the receiver data with either a constant 0x55 or a 16-bit maximal-length LFSR sequence. A clear strobe empties the buffer.

Register map (word index on `regAddr`): 0 data port (read), 1 write pointer, 2 read pointer, 3 test control, 4 capture control, 5 status, 6 interrupt enable, 7 reads zero. `DEPTH` must be a power of two.

Top module: `cap_ring_top`

## Requirements
- R1: After reset, both pointers, the status, control, test and enable registers all read 0, and `irq` is 0.
- R2: A strobe on `sampleValid` stores a sample only while the control bit 0 (record) is 1. With record at 0 the write pointer (register 1) does not move.
- R3: Control bits 3:2 select the sample width: 0 gives 16 bits in one word; 1, 2 and 3 give 18, 20 and 24 bits in two words. In the two-word case the low word is data[15:0] and comes first, and the high word holds the remaining upper bits, zero-extended. Bits above the selected width are stored as 0.
- R4: A read of register 0 returns the word at the read pointer and advances the read pointer by one. A read while the buffer is empty returns 0 and leaves the read pointer unchanged.
- R5: Enable bits 1:0 select the level threshold: 0 means off, 1 means DEPTH/8, 2 means DEPTH/4 and 3 means DEPTH/2. Status bit 0 is 1 while the fill (write pointer minus read pointer, modulo DEPTH) is at or above that threshold, and `irq` follows it.
- R6: A sample that needs more words than DEPTH-1 minus the fill is dropped, so the write pointer does not move. Status bit 1 is then set. It stays set until a write to register 5 with bit 1 at 1 clears it. `irq` includes it only when enable bit 2 is 1.
- R7: Status bit 2 follows `rxIrqIn`. `irq` includes it only when enable bit 3 is 1.
- R8: Test control bit 0 replaces `sampleData` with generated data. Bit 1 selects the constant 0x0055 (0) or an LFSR (1). The LFSR has the polynomial x^16+x^14+x^13+x^11+1, shifts left with the feedback bit entering at bit 0, is seeded with 0xACE1 at reset, and advances once for each stored test sample.
- R9: Writing control bit 1 as 1 empties the buffer: both pointers go to 0, the overrun flag is cleared, and any sample offered in that cycle is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a read of register 0 pops a word) |
| regAddr | input | 3 | Register word index |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, combinational from the current state |
| sampleValid | input | 1 | One incoming sample this cycle |
| sampleData | input | 24 | Incoming sample, right-justified |
| rxIrqIn | input | 1 | Interrupt request from the external receiver |
| irq | output | 1 | Combined interrupt |

## Verification
Every register write, sample strobe and data-port pop takes effect at the first rising edge after it is driven. The bench drives on the falling edge and reads back through the bus no earlier than the next falling edge. `regRdata`, the status bits and `irq` are combinational from registered state. A read is therefore sampled 2 ns after its strobe is applied, before the edge that performs the pop. Status bit 2 is checked in the same cycle that `rxIrqIn` changes, because it is a direct pass-through.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

  // strobes issued by the control unit to the datapath, one cycle wide
  typedef struct packed {
    logic clear;    // empty the buffer
    logic push;     // store the current sample
    logic pushTwo;  // sample occupies two words
    logic pop;      // advance the read pointer
  } dpStrobe_t;

  localparam logic [2:0] ADDR_DATA   = 3'd0;
  localparam logic [2:0] ADDR_WPTR   = 3'd1;
  localparam logic [2:0] ADDR_RPTR   = 3'd2;
  localparam logic [2:0] ADDR_TEST   = 3'd3;
  localparam logic [2:0] ADDR_CTRL   = 3'd4;
  localparam logic [2:0] ADDR_STATUS = 3'd5;
  localparam logic [2:0] ADDR_ENABLE = 3'd6;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [23:0] TEST_CONST = 24'h000055;

endpackage

// File: rtl/cap_ring_dp.sv
module cap_ring_dp
  import cap_ring_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [1:0]    fmt,
  input  logic          testEn,
  input  logic          testSel,
  input  logic [23:0]   sampleData,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic [AW-1:0] fill,
  output logic [15:0]   headWord
);

  logic [15:0]   mem [DEPTH];
  logic [15:0]   lfsr;
  logic [23:0]   srcData;
  logic [23:0]   masked;
  logic [AW-1:0] wrNext1;
  logic          lfsrFb;

  always_comb begin
    if (testEn) srcData = testSel ? {8'h00, lfsr} : TEST_CONST;
    else        srcData = sampleData;
  end

  // right-justified width trim
  always_comb begin
    unique case (fmt)
      2'd0:    masked = {8'h00, srcData[15:0]};
      2'd1:    masked = {6'h00, srcData[17:0]};
      2'd2:    masked = {4'h0, srcData[19:0]};
      default: masked = srcData;
    endcase
  end

  assign wrNext1 = wrPtr + AW'(1);
  assign fill    = wrPtr - rdPtr;
  assign headWord = mem[rdPtr];
  assign lfsrFb  = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      mem[wrPtr] <= masked[15:0];
      if (strobe.pushTwo) mem[wrNext1] <= {8'h00, masked[23:16]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= strobe.pushTwo ? wrPtr + AW'(2) : wrNext1;
      if (strobe.pop)  rdPtr <= rdPtr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               lfsr <= LFSR_SEED;
    else if (strobe.push && testEn && testSel) lfsr <= {lfsr[14:0], lfsrFb};
  end

  // R6: a push never leaves the buffer looking empty
  a_r6_push_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.clear && !strobe.pop) |=> (fill != '0));

endmodule

// File: rtl/cap_ring_ctrl.sv
module cap_ring_ctrl
  import cap_ring_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [2:0]    regAddr,
  input  logic [15:0]   regWdata,
  output logic [15:0]   regRdata,
  input  logic          sampleValid,
  input  logic          rxIrqIn,
  output logic          irq,
  input  logic [AW-1:0] wrPtr,
  input  logic [AW-1:0] rdPtr,
  input  logic [AW-1:0] fill,
  input  logic [15:0]   headWord,
  output dpStrobe_t     strobe,
  output logic [1:0]    fmt,
  output logic          testEn,
  output logic          testSel
);

  logic       recordQ, ovrQ, ovrEnQ, rxEnQ;
  logic [1:0] lvlSelQ;
  logic       clearReq, sampleTake, fits, lvlHit, dataRead, isEmpty;
  logic [AW:0] freeWords, needWords, threshold;
  logic [11:0] unusedWdata;

  assign unusedWdata = regWdata[15:4];

  assign isEmpty    = (fill == '0);
  assign clearReq   = regWr && (regAddr == ADDR_CTRL) && regWdata[1];
  assign sampleTake = recordQ && sampleValid;
  assign dataRead   = regRd && (regAddr == ADDR_DATA);
  assign freeWords  = (AW+1)'(DEPTH - 1) - {1'b0, fill};
  assign needWords  = (fmt == 2'd0) ? (AW+1)'(1) : (AW+1)'(2);
  assign fits       = freeWords >= needWords;

  always_comb begin
    strobe.clear   = clearReq;
    strobe.push    = sampleTake && fits && !clearReq;
    strobe.pushTwo = (fmt != 2'd0);
    strobe.pop     = dataRead && !isEmpty && !clearReq;
  end

  always_comb begin
    unique case (lvlSelQ)
      2'd1:    threshold = (AW+1)'(DEPTH / 8);
      2'd2:    threshold = (AW+1)'(DEPTH / 4);
      2'd3:    threshold = (AW+1)'(DEPTH / 2);
      default: threshold = '0;
    endcase
  end
  assign lvlHit = (lvlSelQ != 2'd0) && ({1'b0, fill} >= threshold);
  assign irq    = lvlHit || (ovrEnQ && ovrQ) || (rxEnQ && rxIrqIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recordQ <= 1'b0;
      fmt     <= 2'd0;
      testEn  <= 1'b0;
      testSel <= 1'b0;
      lvlSelQ <= 2'd0;
      ovrEnQ  <= 1'b0;
      rxEnQ   <= 1'b0;
    end else if (regWr) begin
      unique case (regAddr)
        ADDR_CTRL: begin
          recordQ <= regWdata[0];
          fmt     <= regWdata[3:2];
        end
        ADDR_TEST: begin
          testEn  <= regWdata[0];
          testSel <= regWdata[1];
        end
        ADDR_ENABLE: begin
          lvlSelQ <= regWdata[1:0];
          ovrEnQ  <= regWdata[2];
          rxEnQ   <= regWdata[3];
        end
        default: ;
      endcase
    end
  end

  // sticky overrun: setting wins over a write-one-to-clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ovrQ <= 1'b0;
    else if (clearReq)               ovrQ <= 1'b0;
    else if (sampleTake && !fits)    ovrQ <= 1'b1;
    else if (regWr && regAddr == ADDR_STATUS && regWdata[1]) ovrQ <= 1'b0;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_DATA:   regRdata = isEmpty ? 16'h0000 : headWord;
      ADDR_WPTR:   regRdata = 16'(wrPtr);
      ADDR_RPTR:   regRdata = 16'(rdPtr);
      ADDR_TEST:   regRdata = {14'h0, testSel, testEn};
      ADDR_CTRL:   regRdata = {12'h0, fmt, 1'b0, recordQ};
      ADDR_STATUS: regRdata = {13'h0, rxIrqIn, ovrQ, lvlHit};
      ADDR_ENABLE: regRdata = {12'h0, rxEnQ, ovrEnQ, lvlSelQ};
      default:     regRdata = 16'h0000;
    endcase
  end

  // R2: no recording and no clear means the write pointer holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!recordQ && !clearReq) |=> $stable(wrPtr));

  // R6: a sample that does not fit leaves the write pointer where it was
  a_r6_drop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTake && !fits && !clearReq) |=> $stable(wrPtr));

  // R4: a data-port read of an empty buffer does not move the read pointer
  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && isEmpty && !clearReq) |=> $stable(rdPtr));

  // R4: a data-port read of a non-empty buffer advances the read pointer by one
  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !isEmpty && !clearReq) |=> (rdPtr == AW'($past(rdPtr) + AW'(1))));

  // R9: a clear leaves both pointers at zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (wrPtr == '0 && rdPtr == '0));

endmodule

// File: rtl/cap_ring_top.sv
module cap_ring_top
  import cap_ring_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        sampleValid,
  input  logic [23:0] sampleData,
  input  logic        rxIrqIn,
  output logic        irq
);

  localparam int AW = $clog2(DEPTH);

  dpStrobe_t     strobe;
  logic [1:0]    fmt;
  logic          testEn, testSel;
  logic [AW-1:0] wrPtr, rdPtr, fill;
  logic [15:0]   headWord;

  cap_ring_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sampleValid(sampleValid),
    .rxIrqIn(rxIrqIn), .irq(irq), .wrPtr(wrPtr), .rdPtr(rdPtr), .fill(fill),
    .headWord(headWord), .strobe(strobe), .fmt(fmt), .testEn(testEn),
    .testSel(testSel)
  );

  cap_ring_dp #(.DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fmt(fmt), .testEn(testEn),
    .testSel(testSel), .sampleData(sampleData), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .fill(fill), .headWord(headWord)
  );

endmodule

// File: tb/cap_ring_top_tb.sv
`timescale 1ns/1ps
module cap_ring_top_tb;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleData = 24'h0;
  logic        rxIrqIn = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cap_ring_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sampleValid(sampleValid),
    .sampleData(sampleData), .rxIrqIn(rxIrqIn), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [23:0] data;
    logic [15:0] lo;
    logic [15:0] hi;
  } vec_t;

  // R3 width trim vectors: format, input, expected low word, expected high word
  localparam vec_t VECS [6] = '{
    '{2'd0, 24'hABCDEF, 16'hCDEF, 16'h0000},
    '{2'd1, 24'hABCDEF, 16'hCDEF, 16'h0003},
    '{2'd2, 24'hABCDEF, 16'hCDEF, 16'h000B},
    '{2'd3, 24'hABCDEF, 16'hCDEF, 16'h00AB},
    '{2'd0, 24'h001234, 16'h1234, 16'h0000},
    '{2'd3, 24'hF0000F, 16'h000F, 16'h00F0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = 16'h0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #2 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pushSample(input logic [23:0] d);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = d;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    logic [15:0] rd;
    logic [15:0] w0;
    logic [15:0] seq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #2 check("R1 irq", {15'h0, irq}, 16'h0);
    for (int a = 1; a <= 6; a++) begin
      regRead(3'(a), rd);
      check("R1 register", rd, 16'h0);
    end

    // R2 record off: sample ignored
    pushSample(24'h000777);
    regRead(3'd1, rd);
    check("R2 wptr idle", rd, 16'h0);
    regRead(3'd0, rd);
    check("R4 empty read", rd, 16'h0);
    regRead(3'd2, rd);
    check("R4 rptr held on empty", rd, 16'h0);

    // R3 table walk
    for (int i = 0; i < 6; i++) begin
      regWrite(3'd4, {12'h0, VECS[i].fmt, 2'b01});
      regRead(3'd1, w0);
      pushSample(VECS[i].data);
      regRead(3'd1, rd);
      check("R2 wptr step", rd, w0 + ((VECS[i].fmt == 2'd0) ? 16'd1 : 16'd2));
      regRead(3'd0, rd);
      check("R3 low word", rd, VECS[i].lo);
      if (VECS[i].fmt != 2'd0) begin
        regRead(3'd0, rd);
        check("R3 high word", rd, VECS[i].hi);
      end
      regRead(3'd2, rd);
      check("R4 rptr follows", rd, w0 + ((VECS[i].fmt == 2'd0) ? 16'd1 : 16'd2));
    end

    // R5 level threshold
    regWrite(3'd4, 16'h0002);
    regWrite(3'd4, 16'h0001);
    regWrite(3'd6, 16'h0001);
    for (int i = 0; i < 7; i++) pushSample(24'(i));
    regRead(3'd5, rd);
    check("R5 below eighth", rd & 16'h1, 16'h0);
    #2 check("R5 irq low", {15'h0, irq}, 16'h0);
    pushSample(24'h8);
    regRead(3'd5, rd);
    check("R5 at eighth", rd & 16'h1, 16'h1);
    #2 check("R5 irq high", {15'h0, irq}, 16'h1);
    regWrite(3'd6, 16'h0002);
    regRead(3'd5, rd);
    check("R5 quarter not reached", rd & 16'h1, 16'h0);
    regWrite(3'd6, 16'h0000);
    regRead(3'd5, rd);
    check("R5 disabled", rd & 16'h1, 16'h0);

    // R9 clear
    regWrite(3'd4, 16'h0003);
    regRead(3'd1, rd);
    check("R9 wptr zero", rd, 16'h0);
    regRead(3'd2, rd);
    check("R9 rptr zero", rd, 16'h0);

    // R6 overrun
    for (int i = 0; i < DEPTH - 1; i++) pushSample(24'(i + 16'h100));
    regRead(3'd1, rd);
    check("R6 full wptr", rd, 16'(DEPTH - 1));
    regRead(3'd5, rd);
    check("R6 no overrun yet", rd & 16'h2, 16'h0);
    pushSample(24'h00BEEF);
    regRead(3'd1, rd);
    check("R6 dropped wptr", rd, 16'(DEPTH - 1));
    regRead(3'd5, rd);
    check("R6 overrun set", rd & 16'h2, 16'h2);
    #2 check("R6 irq masked", {15'h0, irq}, 16'h0);
    regWrite(3'd6, 16'h0004);
    #2 check("R6 irq enabled", {15'h0, irq}, 16'h1);
    regRead(3'd0, rd);
    check("R6 oldest kept", rd, 16'h0100);
    regRead(3'd5, rd);
    check("R6 sticky", rd & 16'h2, 16'h2);
    regWrite(3'd5, 16'h0002);
    regRead(3'd5, rd);
    check("R6 cleared", rd & 16'h2, 16'h0);

    // R7 receiver interrupt
    regWrite(3'd6, 16'h0000);
    @(negedge clk);
    rxIrqIn = 1'b1;
    #2 check("R7 irq masked", {15'h0, irq}, 16'h0);
    regRead(3'd5, rd);
    check("R7 status", rd & 16'h4, 16'h4);
    regWrite(3'd6, 16'h0008);
    #2 check("R7 irq enabled", {15'h0, irq}, 16'h1);
    @(negedge clk);
    rxIrqIn = 1'b0;
    #2 check("R7 irq follows", {15'h0, irq}, 16'h0);
    regWrite(3'd6, 16'h0000);

    // R8 test pattern: constant then LFSR
    regWrite(3'd4, 16'h0002);
    regWrite(3'd4, 16'h0009);
    regWrite(3'd3, 16'h0001);
    pushSample(24'hFFFFFF);
    regRead(3'd0, rd);
    check("R8 const low", rd, 16'h0055);
    regRead(3'd0, rd);
    check("R8 const high", rd, 16'h0000);
    regWrite(3'd4, 16'h0001);
    regWrite(3'd3, 16'h0003);
    seq = 16'hACE1;
    for (int i = 0; i < 4; i++) pushSample(24'h123456);
    for (int i = 0; i < 4; i++) begin
      regRead(3'd0, rd);
      check("R8 lfsr word", rd, seq);
      seq = lfsrStep(seq);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule